// File: doc/BRIEF.md
# Bit-Serial NRZI Decoder and Self-Synchronizing Descrambler

This block sits on the receive side of a serial video link. It turns a scrambled, polarity-free line bitstream back into plain NRZ payload bits, one bit per serial clock. It first removes the transition coding, which uses the polynomial x+1: each decoded bit is the XOR of the current line bit and the previous line bit. It then undoes a self-synchronizing scrambler built on x^9+x^4+1. The descrambler needs no seed and no alignment. It recovers the payload from whatever state the far-end scrambler started in, once it has seen enough line bits.

A strobe marks each accepted input bit. Cycles without the strobe leave every piece of state untouched, so a stream broken by idle cycles decodes exactly as a continuous stream would. A single bypass control turns off both stages together and passes raw line bits through, for payloads that are not scrambled. While bypass is high, the decoder and descrambler history keep tracking the line. This means descrambled output is correct as soon as bypass drops.

Top module: `nrzi_descrambler`

## Requirements
- R1: While reset (synchronous, active low) is applied, and in the first cycle after it is released, outValid and outBit are both 0.
- R2: The transition decoder forms decoded[n] = line[n] XOR line[n-1]. Inverting every bit of the line stream therefore leaves the output unchanged once priming is complete.
- R3: With bypass low, outBit = decoded[n] XOR decoded[n-4] XOR decoded[n-9]. This recovers the original payload from a scrambler s[n] = d[n] XOR s[n-4] XOR s[n-9] started from any 9-bit state.
- R4: A bit accepted at clock edge k appears on outBit and outValid immediately after edge k, and holds until the next edge.
- R5: With bypass low, the first 10 bits accepted after reset give outValid = 0. The 11th and later accepted bits give outValid = 1.
- R6: With bypass high, each accepted bit is passed through unchanged to outBit with outValid = 1, without waiting for priming.
- R7: Bits accepted during bypass advance the decoder and descrambler history and the priming count. On the first accepted bit after bypass drops, the output is the correct payload bit and is valid, provided at least 10 bits have been accepted since reset.
- R8: In a cycle with inValid low, outValid is 0 after the next edge and outBit keeps its previous value. No history advances, so a stream with idle gaps decodes the same as the same stream without gaps.
- R9: Applying reset in the middle of a stream returns the outputs to the R1 state and restarts the R5 priming count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Synchronous reset, active low |
| inBit | input | 1 | Received line bit |
| inValid | input | 1 | High when inBit carries a bit to accept |
| bypass | input | 1 | High passes raw bits through, skipping decoding and descrambling |
| outBit | output | 1 | Recovered payload bit, or the raw bit in bypass |
| outValid | output | 1 | High when outBit carries a bit accepted in the previous cycle and priming allows it |

## Verification
The hardest case to reach from the ports is the release of bypass after a stretch of raw traffic. There the output is right only if the hidden history followed the line the whole time. The bench drives this case by scrambling and transition-coding its own payload from a nonzero seed, sending the first dozen line bits with bypass high, and then dropping bypass. It then checks that the very next bit is both valid and equal to the payload. Idle gaps placed at varying positions inside the scrambled stream, and a fully inverted line stream, show that neither gaps nor line polarity disturb recovery.

// File: rtl/nrzi_desc_pkg.sv
package nrzi_desc_pkg;

  // Strobes that the control module sends to the datapath each cycle
  typedef struct packed {
    logic advance;    // accept inBit and shift history
    logic markValid;  // output register carries a valid bit next cycle
    logic passRaw;    // select the raw line bit for the output
  } ctrlStrobes_t;

endpackage

// File: rtl/nrzi_desc_ctrl.sv
module nrzi_desc_ctrl
  import nrzi_desc_pkg::*;
#(
  parameter int PRIME_LEN = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         bypass,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(PRIME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PRIME_LEN);

  logic [CNT_W-1:0] acceptCount;
  logic             primed;

  assign primed = (acceptCount == CNT_FULL);

  // Count accepted bits, including those taken in bypass, and saturate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptCount <= '0;
    end else if (inValid && !primed) begin
      acceptCount <= acceptCount + 1'b1;
    end
  end

  always_comb begin
    strobes.advance   = inValid;
    strobes.passRaw   = bypass;
    strobes.markValid = inValid && (bypass || primed);
  end

endmodule

// File: rtl/nrzi_desc_dpath.sv
module nrzi_desc_dpath
  import nrzi_desc_pkg::*;
#(
  parameter int LONG_TAP  = 9,
  parameter int SHORT_TAP = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inBit,
  input  ctrlStrobes_t strobes,
  output logic         outBit,
  output logic         outValid
);
  logic                prevLine;
  logic [LONG_TAP-1:0] hist;      // hist[k] holds decoded[n-1-k]
  logic                decoded;
  logic                plainBit;

  assign decoded  = inBit ^ prevLine;
  assign plainBit = decoded ^ hist[SHORT_TAP-1] ^ hist[LONG_TAP-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLine <= 1'b0;
      hist     <= '0;
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.markValid;
      if (strobes.advance) begin
        prevLine <= inBit;
        hist     <= {hist[LONG_TAP-2:0], decoded};
        outBit   <= strobes.passRaw ? inBit : plainBit;
      end
    end
  end

endmodule

// File: rtl/nrzi_descrambler.sv
module nrzi_descrambler #(
  parameter int LONG_TAP  = 9,
  parameter int SHORT_TAP = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic inBit,
  input  logic inValid,
  input  logic bypass,
  output logic outBit,
  output logic outValid
);
  // One extra bit covers the unknown line level before the first bit
  localparam int PRIME_LEN = LONG_TAP + 1;

  nrzi_desc_pkg::ctrlStrobes_t strobes;

  nrzi_desc_ctrl #(.PRIME_LEN(PRIME_LEN)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .bypass  (bypass),
    .strobes (strobes)
  );

  nrzi_desc_dpath #(.LONG_TAP(LONG_TAP), .SHORT_TAP(SHORT_TAP)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .inBit    (inBit),
    .strobes  (strobes),
    .outBit   (outBit),
    .outValid (outValid)
  );

endmodule

// File: rtl/nrzi_descrambler_chk.sv
module nrzi_descrambler_chk #(
  parameter int LONG_TAP  = 9,
  parameter int SHORT_TAP = 4
) (
  input logic clk,
  input logic rstN,
  input logic inBit,
  input logic inValid,
  input logic bypass,
  input logic outBit,
  input logic outValid
);
  localparam int PRIME_LEN = LONG_TAP + 1;
  localparam int CNT_W     = $clog2(PRIME_LEN + 1);

  // Line-level model: out = l[n]^l[n-1]^l[n-4]^l[n-5]^l[n-9]^l[n-10]
  logic [LONG_TAP:0]  lineHist;   // lineHist[k] holds line[n-1-k]
  logic [CNT_W-1:0]   seen;
  logic               expBit;
  logic               ready;

  assign ready  = (seen == CNT_W'(PRIME_LEN));
  assign expBit = inBit ^ lineHist[0] ^ lineHist[SHORT_TAP-1] ^ lineHist[SHORT_TAP]
                ^ lineHist[LONG_TAP-1] ^ lineHist[LONG_TAP];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineHist <= '0;
      seen     <= '0;
    end else if (inValid) begin
      lineHist <= {lineHist[LONG_TAP-1:0], inBit};
      if (!ready) seen <= seen + 1'b1;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && !outBit));

  assert_descramble_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !bypass && ready) |=> (outValid && outBit == $past(expBit)));

  assert_prime_hidden_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !bypass && !ready) |=> !outValid);

  assert_bypass_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && bypass) |=> (outValid && outBit == $past(inBit)));

  assert_gap_no_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_gap_holds_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && $past(rstN)) |=> $stable(outBit));

endmodule

bind nrzi_descrambler nrzi_descrambler_chk #(
  .LONG_TAP  (LONG_TAP),
  .SHORT_TAP (SHORT_TAP)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inBit    (inBit),
  .inValid  (inValid),
  .bypass   (bypass),
  .outBit   (outBit),
  .outValid (outValid)
);

// File: tb/sim_nrzi_descrambler.sv
module sim_nrzi_descrambler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inBit = 1'b0;
  logic inValid = 1'b0;
  logic bypass = 1'b0;
  logic outBit;
  logic outValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Bench-side transmitter model
  logic [8:0] scr;
  logic       nrziQ;
  logic       invertLine;
  logic       lastOut;

  // Each entry: {payload[15:0], gapMask[15:0]}; a gap bit inserts an idle cycle
  localparam logic [31:0] VEC [8] = '{
    32'hA5C3_0000, 32'h0000_0101, 32'hFFFF_8000, 32'h1234_0F00,
    32'h8001_0001, 32'h7E3C_2222, 32'hDEAD_0000, 32'h0F0F_C003
  };

  always #2 clk = ~clk;

  nrzi_descrambler u0 (
    .clk(clk), .rstN(rstN), .inBit(inBit), .inValid(inValid),
    .bypass(bypass), .outBit(outBit), .outValid(outValid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic x);
    inValid = v; bypass = b; inBit = x;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic encodeBit(input logic d, output logic l);
    logic s;
    s = d ^ scr[3] ^ scr[8];
    scr = {scr[7:0], s};
    nrziQ = nrziQ ^ s;
    l = nrziQ ^ invertLine;
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; bypass = 1'b0; inBit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid during reset", outValid, 1'b0);
    chk("R1 bit during reset", outBit, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic txInit(input logic [8:0] seed, input logic inv);
    scr = seed; nrziQ = 1'b1; invertLine = inv;
  endtask

  // Send 16 payload bits through the model, checking each recovered bit
  task automatic sendWord(input logic [15:0] pay, input logic [15:0] gaps, input string req);
    logic l;
    for (int i = 15; i >= 0; i--) begin
      if (gaps[i]) begin
        step(1'b0, 1'b0, 1'b1);
        chk("R8 gap drops valid", outValid, 1'b0);
        chk("R8 gap holds bit", outBit, lastOut);
      end
      encodeBit(pay[i], l);
      step(1'b1, 1'b0, l);
      chk({req, " valid"}, outValid, 1'b1);
      chk({req, " data"}, outBit, pay[i]);   // R4: one edge of latency
      lastOut = outBit;
    end
  endtask

  task automatic primeStream();
    logic l;
    for (int i = 0; i < 10; i++) begin
      encodeBit(i[0], l);
      step(1'b1, 1'b0, l);
      chk("R5 priming hidden", outValid, 1'b0);
    end
  endtask

  initial begin
    logic l;
    logic [15:0] raw;
    @(negedge clk);
    doReset();
    @(negedge clk);
    chk("R1 valid after release", outValid, 1'b0);
    chk("R1 bit after release", outBit, 1'b0);

    // Table walk: R3 and R4 over varied payloads, R8 over gap patterns
    txInit(9'h1A5, 1'b0);
    primeStream();
    lastOut = outBit;
    for (int e = 0; e < 8; e++) begin
      sendWord(VEC[e][31:16], VEC[e][15:0], "R3");
    end

    // R9: reset mid-stream, then priming restarts
    doReset();
    @(negedge clk);
    chk("R9 valid after mid reset", outValid, 1'b0);
    txInit(9'h0C2, 1'b0);
    encodeBit(1'b1, l);
    step(1'b1, 1'b0, l);
    chk("R9 priming restarts", outValid, 1'b0);

    // R2: fully inverted line stream
    doReset();
    txInit(9'h133, 1'b1);
    primeStream();
    lastOut = outBit;
    sendWord(16'hC3A5, 16'h0000, "R2 inverted line");
    sendWord(16'h5A0F, 16'h0000, "R2 inverted line");

    // R6: bypass passes raw bits straight after reset
    doReset();
    raw = 16'hB2E1;
    for (int i = 15; i >= 0; i--) begin
      step(1'b1, 1'b1, raw[i]);
      chk("R6 bypass valid", outValid, 1'b1);
      chk("R6 bypass data", outBit, raw[i]);
    end

    // R7: history tracks the line during bypass, release is seamless
    doReset();
    txInit(9'h0F1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      encodeBit(i[1], l);
      step(1'b1, 1'b1, l);
      chk("R7 raw during bypass", outBit, l);
    end
    lastOut = outBit;
    encodeBit(1'b1, l);
    step(1'b1, 1'b0, l);
    chk("R7 first bit after release valid", outValid, 1'b1);
    chk("R7 first bit after release data", outBit, 1'b1);
    lastOut = outBit;
    sendWord(16'h6C93, 16'h0410, "R7 after release");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule